// File: doc/BRIEF.md
# Shift-Prescaled Four-Channel PWM Unit

This peripheral drives four pulse-width outputs from one shared free-running counter. A configurable right shift selects a 16-bit window of that counter (the scaled count), and each channel compares the window against its own 16-bit threshold. A channel's output is held low (its active level) while the scaled count is below the threshold, and high otherwise. A threshold of zero therefore gives no active time. No threshold can give a fully active period, because the output is high when the scaled count is 0xFFFF.

The period is set by the shift amount, not by a period register. The window spans `16 + scale` bits of the counter, so without the restart option the counter returns to zero after 2^(16+scale) clocks. If the zero-on-compare option is set, channel 0's threshold ends the period early instead. Counting runs continuously, or for a single period in one-shot mode. Each channel has a pending flag that latches when its threshold is reached. Software reads and writes all state through a simple single-cycle register port.

Top module: `scaled_pwm`

## Requirements
- R1: The registers are at these byte addresses: settings 0x00, counter 0x08, scaled count 0x10, channel n threshold at 0x20 + 4n. Reads of any other address return 0.
- R2: Settings word layout: bits [3:0] hold the shift, bit 9 is zero-on-compare, bit 12 is continuous run and bit 13 is one-shot run. Bits 8, 10, 16 and 24 are stored and read back but have no effect. Bits [31:28] are the pending flags of channels 0 to 3.
- R3: The counter advances by one on every clock while either run bit is set, and holds otherwise. A bus write to the counter loads it and takes priority over counting.
- R4: The scaled count equals counter bits [15+scale : scale]. Bus writes to its address are ignored.
- R5: `pwm_out[n]` is 0 while the scaled count is below threshold n, and 1 otherwise. A threshold of 0 keeps the output at 1.
- R6: Without zero-on-compare, the counter returns to 0 on the clock after its low 16+scale bits are all ones.
- R7: With zero-on-compare set and the unit running, the counter returns to 0 on the clock after the scaled count is at or above threshold 0.
- R8: In one-shot mode, the one-shot bit clears on the same clock that the counter returns to 0, unless the settings word is written on that clock.
- R9: Pending flag n is set on every running clock where the scaled count is at or above threshold n. Only a settings write clears it. If a hardware set and a software clear fall on the same clock, the set wins.
- R10: After reset all registers are 0 and all four outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per asserted clock |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 4 | Channel outputs, low while active |

## Verification
Two events can fall on the same clock. A software write that clears the pending flags can coincide with a running clock on which the comparators still see the scaled count at or above their thresholds. The bench provokes this by rewriting the settings word with zero pending bits while the counter is parked above every threshold with continuous run on. It expects the flags to survive, and expects them to clear only on a later write made while the unit is stopped. A second collision is a one-shot period ending on the same clock as a settings write. The behavioural model predicts both, and the bench compares the model against the outputs and read data on every clock.

// File: rtl/scaled_pwm.sv
`timescale 1ns/1ps
module scaled_pwm #(
  parameter int NCH     = 4,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4,
  parameter int AW      = 8,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int CNT_W = CMP_W + (1 << SCALE_W) - 1;
  localparam logic [AW-1:0] A_CFG = AW'(8'h00);
  localparam logic [AW-1:0] A_CNT = AW'(8'h08);
  localparam logic [AW-1:0] A_SCL = AW'(8'h10);
  localparam logic [AW-1:0] A_CMP = AW'(8'h20);
  localparam int B_STICKY = 8, B_ZERO = 9, B_DGL = 10, B_ALW = 12, B_ONE = 13;
  localparam int B_CTR = 16, B_GANG = 24, B_IP = 28;

  logic [SCALE_W-1:0] scale;
  logic f_sticky, f_zero, f_dgl, f_always, f_once, f_ctr, f_gang;
  logic [NCH-1:0]   ip;
  logic [CNT_W-1:0] count;
  logic [CMP_W-1:0] cmp_q [NCH];
  logic [NCH-1:0]   hit;
  logic [CMP_W-1:0] scaled;
  logic [CNT_W-1:0] win_mask;
  logic [DW-1:0]    cfg_word;

  wire run     = f_always | f_once;
  wire cfg_we  = bus_we && (bus_addr == A_CFG);
  wire cnt_we  = bus_we && (bus_addr == A_CNT);

  assign scaled     = CMP_W'(count >> scale);
  assign win_mask   = ~({CNT_W{1'b1}} << (CMP_W + int'(scale)));
  wire period_end   = (count & win_mask) == win_mask;
  wire restart      = (f_zero & hit[0]) | period_end;

  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_ch
      wire cmp_we = bus_we && (bus_addr == A_CMP + AW'(4 * n));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_q[n] <= '0;
        else if (cmp_we) cmp_q[n] <= bus_wdata[CMP_W-1:0];
      end
      assign hit[n]     = scaled >= cmp_q[n];
      assign pwm_out[n] = hit[n];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale <= '0; f_sticky <= 1'b0; f_zero <= 1'b0; f_dgl <= 1'b0;
      f_always <= 1'b0; f_once <= 1'b0; f_ctr <= 1'b0; f_gang <= 1'b0;
    end else if (cfg_we) begin
      scale    <= bus_wdata[SCALE_W-1:0];
      f_sticky <= bus_wdata[B_STICKY];
      f_zero   <= bus_wdata[B_ZERO];
      f_dgl    <= bus_wdata[B_DGL];
      f_always <= bus_wdata[B_ALW];
      f_once   <= bus_wdata[B_ONE];
      f_ctr    <= bus_wdata[B_CTR];
      f_gang   <= bus_wdata[B_GANG];
    end else if (f_once && restart) begin
      f_once <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ip <= '0;
    else        ip <= (cfg_we ? bus_wdata[B_IP +: NCH] : ip) | (run ? hit : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (cnt_we)  count <= bus_wdata[CNT_W-1:0];
    else if (run)     count <= restart ? '0 : count + 1'b1;
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[SCALE_W-1:0] = scale;
    cfg_word[B_STICKY] = f_sticky;
    cfg_word[B_ZERO]   = f_zero;
    cfg_word[B_DGL]    = f_dgl;
    cfg_word[B_ALW]    = f_always;
    cfg_word[B_ONE]    = f_once;
    cfg_word[B_CTR]    = f_ctr;
    cfg_word[B_GANG]   = f_gang;
    cfg_word[B_IP +: NCH] = ip;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CFG) bus_rdata = cfg_word;
    if (bus_addr == A_CNT) bus_rdata = DW'(count);
    if (bus_addr == A_SCL) bus_rdata = DW'(scaled);
    for (int k = 0; k < NCH; k++)
      if (bus_addr == A_CMP + AW'(4 * k)) bus_rdata = DW'(cmp_q[k]);
  end
endmodule

module scaled_pwm_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 31,
  parameter int AW    = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] ip,
  input logic [CNT_W-1:0] count,
  input logic           f_always,
  input logic           f_once,
  input logic           f_zero
);
  wire run  = f_always | f_once;
  wire c_we = bus_we && (bus_addr == AW'(8'h08));
  wire s_we = bus_we && (bus_addr == AW'(8'h00));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !c_we |=> $stable(count));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && !c_we && !f_zero && count[15:0] != 16'hFFFF |=> count == $past(count) + CNT_W'(1));

  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    run && f_zero && pwm_out[0] && !c_we |=> count == '0);

  a_r8_once_clear: assert property (@(posedge clk) disable iff (!rst_n)
    f_once && !s_we && !c_we |=> f_once || count == '0);

  a_r9_pending: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (ip & $past(pwm_out)) == $past(pwm_out));
endmodule

bind scaled_pwm scaled_pwm_chk #(.NCH(NCH), .CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .pwm_out(pwm_out), .ip(ip), .count(count), .f_always(f_always),
  .f_once(f_once), .f_zero(f_zero)
);

// File: tb/scaled_pwm_tb.sv
`timescale 1ns/1ps
module scaled_pwm_tb;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [3:0]  pwm_out;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scaled_pwm u_dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  // behavioural reference
  longint m_cnt;
  int m_scale, m_cmp[4];
  bit m_st, m_zc, m_dg, m_ea, m_eo, m_ct, m_gg;
  bit [3:0] m_ip;

  function automatic int m_scaled();
    return int'((m_cnt >> m_scale) % 65536);
  endfunction

  function automatic bit [3:0] m_hit();
    bit [3:0] h;
    for (int i = 0; i < 4; i++) h[i] = m_scaled() >= m_cmp[i];
    return h;
  endfunction

  function automatic longint m_read(int a);
    longint w;
    if (a == 0) begin
      w = m_scale + m_st * 256 + m_zc * 512 + m_dg * 1024 + m_ea * 4096 + m_eo * 8192
          + m_ct * 65536 + m_gg * 16777216 + longint'(m_ip) * 268435456;
      return w;
    end
    if (a == 8)  return m_cnt;
    if (a == 16) return m_scaled();
    for (int i = 0; i < 4; i++) if (a == 32 + 4 * i) return m_cmp[i];
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_scale = 0; m_st = 0; m_zc = 0; m_dg = 0; m_ea = 0; m_eo = 0;
      m_ct = 0; m_gg = 0; m_ip = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    end else begin
      bit run, rst_cnt, cfg_w;
      bit [3:0] h;
      longint win;
      run = m_ea || m_eo;
      h = m_hit();
      win = longint'(1) << (16 + m_scale);
      rst_cnt = (m_zc && h[0]) || ((m_cnt + 1) % win == 0);
      cfg_w = bus_we && bus_addr == 0;
      if (cfg_w) m_ip = bus_wdata[31:28];
      if (run) m_ip = m_ip | h;
      if (cfg_w) begin
        m_scale = int'(bus_wdata[3:0]); m_st = bus_wdata[8]; m_zc = bus_wdata[9];
        m_dg = bus_wdata[10]; m_ea = bus_wdata[12]; m_eo = bus_wdata[13];
        m_ct = bus_wdata[16]; m_gg = bus_wdata[24];
      end else if (run && m_eo && rst_cnt) m_eo = 0;
      if (bus_we && bus_addr == 8) m_cnt = longint'(bus_wdata) % (longint'(1) << 31);
      else if (run) m_cnt = rst_cnt ? 0 : m_cnt + 1;
      for (int i = 0; i < 4; i++)
        if (bus_we && bus_addr == 8'(32 + 4 * i)) m_cmp[i] = int'(bus_wdata[15:0]);
    end
  end

  task automatic chk(string tag, longint got, longint exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    tests += 2;
    if (pwm_out !== m_hit()) begin
      fails++;
      if (fails < 20) $display("FAIL R5 pwm_out got=%0h exp=%0h t=%0t", pwm_out, m_hit(), $time);
    end
    if (longint'(bus_rdata) != m_read(int'(bus_addr))) begin
      fails++;
      if (fails < 20) $display("FAIL R1 rdata @%0h got=%0h exp=%0h", bus_addr, bus_rdata, m_read(int'(bus_addr)));
    end
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) begin
      bus_addr = 8'((i % 8) * 8) & 8'h38;
      if (bus_addr == 8'h18) bus_addr = 8'h24;
      tick();
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output longint v);
    bus_addr = a; #1; v = longint'(bus_rdata);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    longint v, c1, c2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h00, v); chk("R10 cfg", v, 0);
    rd(8'h08, v); chk("R10 count", v, 0);
    chk("R10 outputs", longint'(pwm_out), 4'hF);

    // continuous, zero-on-compare, scale 0
    wr(8'h20, 40); wr(8'h24, 10); wr(8'h28, 25); wr(8'h2C, 0);
    wr(8'h00, (1 << 12) | (1 << 9));
    run_n(150);
    rd(8'h00, v); chk("R9 pending all", (v >> 28) & 15, 15);
    rd(8'h08, v); chk("R7 count bounded", longint'(v <= 40), 1);

    // scale 2
    wr(8'h00, (1 << 12) | (1 << 9) | 2);
    run_n(400);
    rd(8'h08, c1); rd(8'h10, v); chk("R4 scaled window", v, (c1 >> 2) & 16'hFFFF);

    // counter load and step, scaled write ignored
    wr(8'h00, (1 << 12));
    wr(8'h08, 1000);
    rd(8'h08, v); chk("R3 load", v, 1000);
    tick(); rd(8'h08, v); chk("R3 step", v, 1001);
    wr(8'h10, 5);
    rd(8'h08, c1); rd(8'h10, v); chk("R4 write ignored", v, c1 & 16'hFFFF);

    // stop and hold
    wr(8'h00, 0);
    rd(8'h08, c1); run_n(5); rd(8'h08, c2); chk("R3 hold", c2, c1);

    // pending: set wins over clear, then clear while stopped
    wr(8'h00, (1 << 12));
    wr(8'h00, (1 << 12));
    rd(8'h00, v); chk("R9 set beats clear", (v >> 28) & 15, 15);
    wr(8'h00, 0);
    wr(8'h00, 0);
    rd(8'h00, v); chk("R9 clear", (v >> 28) & 15, 0);

    // inert bits and decode
    rd(8'h08, c1);
    wr(8'h00, 32'h0101_0500);
    rd(8'h00, v); chk("R2 inert bits", v, 32'h0101_0500);
    run_n(4); rd(8'h08, v); chk("R2 no effect", v, c1);
    rd(8'h44, v); chk("R1 unmapped", v, 0);
    rd(8'h28, v); chk("R1 threshold 2", v, 25);

    // one-shot with zero-on-compare
    wr(8'h00, 0); wr(8'h08, 0); wr(8'h20, 30);
    wr(8'h00, (1 << 13) | (1 << 9));
    run_n(60);
    rd(8'h00, v); chk("R8 once cleared", (v >> 13) & 1, 0);
    rd(8'h08, v); chk("R8 stopped at zero", v, 0);

    // one-shot with natural wrap, scale 0
    wr(8'h00, 0); wr(8'h08, 32'hFFF0);
    wr(8'h00, (1 << 13));
    run_n(40);
    rd(8'h00, v); chk("R8 once wrap", (v >> 13) & 1, 0);
    rd(8'h08, v); chk("R6 wrap scale 0", v, 0);

    // wrap at scale 3 and scale 15
    wr(8'h00, 0); wr(8'h08, (1 << 19) - 3);
    wr(8'h00, (1 << 12) | 3);
    tick(); tick(); rd(8'h08, v); chk("R6 edge scale 3", v, (1 << 19) - 1);
    tick(); rd(8'h08, v); chk("R6 wrap scale 3", v, 0);
    wr(8'h00, 0); wr(8'h08, 32'h7FFF_FFFE);
    wr(8'h00, (1 << 12) | 15);
    tick(); tick(); rd(8'h08, v); chk("R6 wrap scale 15", v, 0);

    // threshold at top of range
    wr(8'h00, 0); wr(8'h24, 16'hFFFF);
    wr(8'h08, 16'hFFFE); chk("R5 below max", longint'(pwm_out[1]), 0);
    wr(8'h08, 16'hFFFF); chk("R5 at max", longint'(pwm_out[1]), 1);
    wr(8'h2C, 0); chk("R5 zero threshold", longint'(pwm_out[3]), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule